// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit core whose register mapping follows a 5-bit operating-mode code. Sixteen logical register numbers map onto physical storage. Registers r0 to r7 are one shared set. The fast-interrupt mode has its own r8 to r14. The other four exception modes each have their own r13 (stack pointer) and r14 (link register). Every exception mode also owns one saved status register, which has a separate read and write port.

Two combinational read ports and one write port serve the execute stage. The write port commits on the rising clock edge. Logical register 15 does not refer to storage: reads of it return the current instruction address, supplied from outside, plus 8. A user-bank override input makes both reads and writes use the user-mode mapping, whatever the current mode is. Privileged block transfers use it to reach the user copies.

Top module: `bankRegFile`

## Requirements
- R1: After reset every stored register and every saved status register reads as zero.
- R2: Logical r0 to r7 map to the same storage in every mode code, so a value written in one mode reads back in any other.
- R3: Mode codes 10000 and 11111 use the same storage for all of r0 to r14.
- R4: Mode code 10001 has private r8 to r14. Writes made there are not seen in other modes, and writes made in other modes do not change them.
- R5: Mode codes 10010, 10011, 10111 and 11011 each have private r13 and r14. Their r8 to r12 are the user-mode storage.
- R6: Each of the five exception mode codes has its own saved status register, read combinationally and written on the clock edge. In modes 10000 and 11111 it reads as zero and writes to it are discarded.
- R7: A read of logical r15 on either port returns the instruction-address input plus 8, modulo 2^32. A write addressed to r15 changes no storage.
- R8: While the override input is 1, register reads and writes use the user-mode mapping. The saved status port still follows the mode code.
- R9: Any mode code not listed above maps registers as user mode and has no saved status register.
- R10: A write becomes visible in the cycle after its clock edge. A same-cycle read of the register being written returns the old value.
- R11: The two read ports are independent and may address any registers at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeIn | input | 5 | Current operating-mode code |
| userBankIn | input | 1 | Forces the user-mode register mapping |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write number |
| wrData | input | 32 | Register write data |
| pcIn | input | 32 | Address of the current instruction |
| savedRdData | output | 32 | Saved status register of the current mode |
| savedWrEn | input | 1 | Saved status write enable |
| savedWrData | input | 32 | Saved status write data |

## Verification
The hardest case to reach is aliasing between banks. A fault that points one mode's r13 or r14 at another mode's storage only shows up when every bank holds a different value and each one is then read from every mode. The stimulus writes a tag made from the mode and the register number into r0 to r15 under all seven mode codes and one unknown code. It then reads all sixteen registers back on both ports under every mode, with the override off and then on. A second round of writes made with the override on follows, and the full readback is repeated.

// File: rtl/bankRegFilePkg.sv
package bankRegFilePkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } modeCodeT;

  // Bank order matters: the banks from BANK_IRQ upward hold only r13/r14.
  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bankT;

  typedef struct packed {
    bankT regBank;    // mapping used by the register ports
    bankT statBank;   // bank owning the saved status register
    logic statValid;  // current mode has a saved status register
    logic regWrStb;   // commit a register write
    logic statWrStb;  // commit a saved status write
  } ctrlStrobeT;

endpackage

// File: rtl/bankRegFileCtrl.sv
module bankRegFileCtrl
  import bankRegFilePkg::*;
(
  input  logic [4:0]  modeIn,
  input  logic        userBankIn,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic        savedWrEn,
  output ctrlStrobeT  ctrlOut
);

  bankT modeBank;

  always_comb begin
    case (modeIn)
      MODE_FIQ: modeBank = BANK_FIQ;
      MODE_IRQ: modeBank = BANK_IRQ;
      MODE_SVC: modeBank = BANK_SVC;
      MODE_ABT: modeBank = BANK_ABT;
      MODE_UND: modeBank = BANK_UND;
      default:  modeBank = BANK_USR;  // user, system and unknown codes
    endcase
  end

  always_comb begin
    ctrlOut.regBank   = userBankIn ? BANK_USR : modeBank;
    ctrlOut.statBank  = modeBank;
    ctrlOut.statValid = (modeBank != BANK_USR);
    ctrlOut.regWrStb  = wrEn && (wrAddr != 4'hF);
    ctrlOut.statWrStb = savedWrEn && (modeBank != BANK_USR);
  end

endmodule

// File: rtl/bankRegFileDp.sv
module bankRegFileDp
  import bankRegFilePkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        ctrlIn,
  input  logic [3:0]        rdAddrA,
  input  logic [3:0]        rdAddrB,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] savedWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] savedRdData
);

  localparam int NUM_SHARED = 15;                       // r0..r14 of user mode
  localparam int FIQ_FIRST  = 8;
  localparam int NUM_FIQ    = NUM_SHARED - FIQ_FIRST;   // r8..r14 fast bank
  localparam int SP_REG     = 13;
  localparam int NUM_SMALL  = 4;                        // banks with r13/r14 only
  localparam int NUM_PHYS   = NUM_SHARED + NUM_FIQ + 2 * NUM_SMALL;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int NUM_STAT   = 5;
  localparam int STAT_W     = $clog2(NUM_STAT);

  logic [DATA_W-1:0] physRegs [NUM_PHYS];
  logic [DATA_W-1:0] statRegs [NUM_STAT];
  logic [NUM_PHYS-1:0] physWrSel;
  logic [NUM_STAT-1:0] statWrSel;
  logic [PHYS_W-1:0]   wrPhys;
  logic [STAT_W-1:0]   statIdx;

  function automatic logic [PHYS_W-1:0] physIdx(bankT bank, logic [3:0] regNum);
    int r;
    int b;
    int idx;
    r = int'(regNum);
    b = int'(bank);
    if (bank == BANK_FIQ && r >= FIQ_FIRST)
      idx = NUM_SHARED + r - FIQ_FIRST;
    else if (b >= int'(BANK_IRQ) && r >= SP_REG)
      idx = NUM_SHARED + NUM_FIQ + 2 * (b - int'(BANK_IRQ)) + (r - SP_REG);
    else
      idx = r;
    return PHYS_W'(idx);
  endfunction

  assign wrPhys  = physIdx(ctrlIn.regBank, wrAddr);
  assign statIdx = STAT_W'(int'(ctrlIn.statBank) - 1);

  always_comb begin
    physWrSel = '0;
    if (ctrlIn.regWrStb) physWrSel[wrPhys] = 1'b1;
    statWrSel = '0;
    if (ctrlIn.statWrStb) statWrSel[statIdx] = 1'b1;
  end

  for (genvar g = 0; g < NUM_PHYS; g++) begin : gPhys
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             physRegs[g] <= '0;
      else if (physWrSel[g]) physRegs[g] <= wrData;
    end
  end

  for (genvar s = 0; s < NUM_STAT; s++) begin : gStat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             statRegs[s] <= '0;
      else if (statWrSel[s]) statRegs[s] <= savedWrData;
    end
  end

  assign rdDataA = (rdAddrA == 4'hF) ? pcIn + DATA_W'(PC_OFFSET)
                                     : physRegs[physIdx(ctrlIn.regBank, rdAddrA)];
  assign rdDataB = (rdAddrB == 4'hF) ? pcIn + DATA_W'(PC_OFFSET)
                                     : physRegs[physIdx(ctrlIn.regBank, rdAddrB)];
  assign savedRdData = ctrlIn.statValid ? statRegs[statIdx] : '0;

endmodule

// File: rtl/bankRegFile.sv
module bankRegFile
  import bankRegFilePkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        modeIn,
  input  logic              userBankIn,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] savedRdData,
  input  logic              savedWrEn,
  input  logic [DATA_W-1:0] savedWrData
);

  ctrlStrobeT ctrlBus;

  bankRegFileCtrl u_ctrl (
    .modeIn     (modeIn),
    .userBankIn (userBankIn),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .savedWrEn  (savedWrEn),
    .ctrlOut    (ctrlBus)
  );

  bankRegFileDp #(
    .DATA_W    (DATA_W),
    .PC_OFFSET (PC_OFFSET)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlIn      (ctrlBus),
    .rdAddrA     (rdAddrA),
    .rdAddrB     (rdAddrB),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .pcIn        (pcIn),
    .savedWrData (savedWrData),
    .rdDataA     (rdDataA),
    .rdDataB     (rdDataB),
    .savedRdData (savedRdData)
  );

endmodule

// File: rtl/bankRegFileChk.sv
module bankRegFileChk #(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        modeIn,
  input logic              userBankIn,
  input logic [3:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [3:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [3:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] pcIn,
  input logic [DATA_W-1:0] savedRdData,
  input logic              savedWrEn,
  input logic [DATA_W-1:0] savedWrData
);

  // High once a full clock cycle out of reset has passed, so $past is valid.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_PC_VIEW_A: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrA == 4'hF |-> rdDataA == pcIn + DATA_W'(PC_OFFSET)); // R7

  AST_PC_VIEW_B: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrB == 4'hF |-> rdDataB == pcIn + DATA_W'(PC_OFFSET)); // R11

  AST_NO_SAVED_USER: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == 5'b10000 || modeIn == 5'b11111) |-> savedRdData == '0); // R6

  AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wrEn && wrAddr < 4'd8) |=>
      (rdAddrA != $past(wrAddr) || rdDataA == $past(wrData))); // R2

  AST_SAVED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && savedWrEn && modeIn == 5'b10001) |=>
      (modeIn != 5'b10001 || savedRdData == $past(savedWrData))); // R6

  AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(wrEn) && $stable(modeIn) && $stable(userBankIn) &&
     $stable(rdAddrA) && rdAddrA != 4'hF) |-> $stable(rdDataA)); // R10

endmodule

bind bankRegFile bankRegFileChk #(.DATA_W(DATA_W), .PC_OFFSET(PC_OFFSET)) u_chk (.*);

// File: tb/bankRegFile_tb.sv
module bankRegFile_tb;

  localparam int CLK_NS = 8;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111, M_BAD = 5'b00110;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  modeIn = M_USR;
  logic        userBankIn = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, savedRdData;
  logic        wrEn = 1'b0, savedWrEn = 1'b0;
  logic [31:0] wrData = '0, pcIn = '0, savedWrData = '0;

  int checkCnt = 0;
  int failCnt = 0;

  logic [31:0] shadow [6][16];
  logic [31:0] statShadow [6];
  logic [4:0]  modeList [8];

  always #(CLK_NS / 2) clk = ~clk;

  bankRegFile u_dut (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .userBankIn(userBankIn),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pcIn(pcIn),
    .savedRdData(savedRdData), .savedWrEn(savedWrEn), .savedWrData(savedWrData)
  );

  function automatic int modeGrp(logic [4:0] m);
    case (m)
      M_FIQ: return 1;
      M_IRQ: return 2;
      M_SVC: return 3;
      M_ABT: return 4;
      M_UND: return 5;
      default: return 0;
    endcase
  endfunction

  // Storage group a logical register resolves to, from the requirements.
  function automatic int regGrp(logic [4:0] m, bit ovr, int r);
    int g;
    g = ovr ? 0 : modeGrp(m);
    if (r < 8) return 0;
    if (g >= 2 && r < 13) return 0;
    return g;
  endfunction

  function automatic string reqTag(logic [4:0] m, bit ovr, int r);
    if (r == 15) return "R7";
    if (r < 8) return "R2";
    if (ovr) return "R8";
    if (m == M_FIQ) return "R4";
    if (modeGrp(m) >= 2) return "R5";
    if (m == M_SYS || m == M_USR) return "R3";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  task automatic regWrite(logic [4:0] m, bit ovr, int r, logic [31:0] v);
    @(negedge clk);
    modeIn = m; userBankIn = ovr; wrEn = 1'b1; wrAddr = 4'(r); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    if (r != 15) shadow[regGrp(m, ovr, r)][r] = v;
  endtask

  task automatic readAll(logic [31:0] pcBase);
    for (int mi = 0; mi < 8; mi++) begin
      for (int ov = 0; ov < 2; ov++) begin
        for (int r = 0; r < 16; r++) begin
          logic [31:0] expA, expB;
          int rb;
          rb = 15 - r;
          @(negedge clk);
          modeIn = modeList[mi]; userBankIn = ov[0];
          rdAddrA = 4'(r); rdAddrB = 4'(rb);
          pcIn = pcBase + 32'(mi * 64 + r * 4);
          #1;
          expA = (r == 15) ? pcIn + 32'd8 : shadow[regGrp(modeList[mi], ov[0], r)][r];
          expB = (rb == 15) ? pcIn + 32'd8 : shadow[regGrp(modeList[mi], ov[0], rb)][rb];
          chk(reqTag(modeList[mi], ov[0], r), rdDataA, expA);
          chk("R11", rdDataB, expB);
        end
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    modeList[0] = M_USR; modeList[1] = M_FIQ; modeList[2] = M_IRQ; modeList[3] = M_SVC;
    modeList[4] = M_ABT; modeList[5] = M_UND; modeList[6] = M_SYS; modeList[7] = M_BAD;
    for (int g = 0; g < 6; g++) begin
      statShadow[g] = '0;
      for (int r = 0; r < 16; r++) shadow[g][r] = '0;
    end

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: everything zero after reset, seen through every mapping
    for (int mi = 0; mi < 8; mi++) begin
      for (int r = 0; r < 15; r++) begin
        @(negedge clk);
        modeIn = modeList[mi]; rdAddrA = 4'(r); rdAddrB = 4'(14 - r);
        #1;
        chk("R1", rdDataA, 32'h0);
      end
      chk("R1", savedRdData, 32'h0);
    end

    // R2..R5, R7, R9: tagged writes from every mode code
    for (int mi = 0; mi < 8; mi++)
      for (int r = 0; r < 16; r++)
        regWrite(modeList[mi], 1'b0, r, 32'hC000_0000 | 32'(mi << 8) | 32'(r));
    readAll(32'h0000_1000);

    // R8: writes under the override from banked modes land in user storage
    for (int r = 0; r < 15; r++) begin
      regWrite(M_FIQ, 1'b1, r, 32'h5A00_0000 | 32'(r));
      regWrite(M_UND, 1'b1, r, 32'h6B00_0000 | 32'(r));
    end
    readAll(32'hFFFF_FF00);  // R7: includes the wrap past 2^32

    // R6, R9: saved status written from every code, user/system/unknown discarded
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk);
      modeIn = modeList[mi]; userBankIn = 1'b0;
      savedWrEn = 1'b1; savedWrData = 32'h7700_0000 | 32'(mi);
      @(negedge clk);
      savedWrEn = 1'b0;
      if (modeGrp(modeList[mi]) != 0) statShadow[modeGrp(modeList[mi])] = 32'h7700_0000 | 32'(mi);
    end
    // R8: saved port follows the mode code even with the override set
    @(negedge clk);
    modeIn = M_SVC; userBankIn = 1'b1; savedWrEn = 1'b1; savedWrData = 32'hABCD_0003;
    @(negedge clk);
    savedWrEn = 1'b0; userBankIn = 1'b0;
    statShadow[3] = 32'hABCD_0003;
    #1;
    chk("R8", savedRdData, 32'hABCD_0003);
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk);
      modeIn = modeList[mi];
      #1;
      chk("R6", savedRdData, modeGrp(modeList[mi]) == 0 ? 32'h0 : statShadow[modeGrp(modeList[mi])]);
    end

    // R10: same-cycle read shows the old value, next cycle the new one
    @(negedge clk);
    modeIn = M_IRQ; userBankIn = 1'b0; rdAddrA = 4'd13;
    wrEn = 1'b1; wrAddr = 4'd13; wrData = 32'hDEAD_BEEF;
    #1;
    chk("R10", rdDataA, shadow[2][13]);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    chk("R10", rdDataA, 32'hDEAD_BEEF);
    shadow[2][13] = 32'hDEAD_BEEF;
    @(negedge clk);
    modeIn = M_SVC;
    #1;
    chk("R5", rdDataA, shadow[3][13]);

    finishRun();
  end

endmodule